// File: doc/BRIEF.md
# PHY Timing Mode and DLL Configurator

This block brings the I/O PHY of a storage-card host controller into line with a newly selected bus timing mode. When the card clock setting changes, it takes a timing-mode code, a card clock frequency code and a 2-bit drive strength. It then drives a fixed series of accesses on an 8-bit PHY register port: the mode bits, an optional read-modify-write of the pad control register, the output and input tap delays, the DLL trim value, and the DLL clear and enable writes. In every mode except legacy it finishes by polling the DLL ready flag.

A one-cycle `start` launches a request. If the frequency code matches the last one applied, the block does no PHY access and reports completion on the next cycle. A start that arrives while a sequence is running is held and launched once the current sequence completes; if several arrive, the newest wins. A register access that is not acknowledged in time, or a DLL that never reports ready, ends the sequence with `error` raised alongside `done`.

The controller is a single state machine with these states: S_IDLE, S_SET_MODE, S_PAD_READ, S_PAD_WRITE, S_OUT_TAP, S_IN_TAP, S_TRIM, S_DLL_CLEAR, S_DLL_ENABLE, S_DLL_POLL and S_FINISH. From S_IDLE, an accepted request moves to S_SET_MODE, or to S_FINISH when it is skipped. S_SET_MODE moves to S_PAD_READ in the two pad-adjusting modes, to S_FINISH when the mode code is unused, and to S_OUT_TAP otherwise. S_PAD_READ leads to S_PAD_WRITE, and S_PAD_WRITE leads to S_OUT_TAP. S_OUT_TAP leads to S_IN_TAP. S_IN_TAP leads to S_TRIM, or to S_DLL_CLEAR in legacy mode. S_TRIM leads to S_DLL_CLEAR. S_DLL_CLEAR leads to S_DLL_ENABLE, or to S_FINISH in legacy mode. S_DLL_ENABLE leads to S_DLL_POLL. S_DLL_POLL stays in place until the DLL reports ready or the poll times out, then moves to S_FINISH. A failed access in any access state goes straight to S_FINISH. S_FINISH always returns to S_IDLE.

Top module: `phy_timing_cfg`

## Requirements
- R1: The first PHY access of a sequence is a write to address 0x11. Its value depends on `mode` (0 legacy, 1 high-speed, 2 HS200, 3 DDR50, 4 HS400, 5 enhanced strobe): legacy 0x04, DDR50 0x08, HS400 0x02, enhanced strobe 0x01, and 0x00 for both high-speed and HS200.
- R2: Only in HS200 and HS400 mode, the mode write is followed by a read of address 0x01 and then a write to 0x01 of the value read ORed with `drv` shifted left by 2.
- R3: Next comes a write to 0x0D (output tap), then a write to 0x0C (input tap). In legacy mode both are 0. Otherwise, for a tap pair (o,i), the output tap gets o*2+1 and the input tap gets i*2+1. The pairs are high-speed (3,2), DDR50 (1,0), HS400 (1,10), enhanced strobe (1,0), and HS200 output 2 with the input tap written as 0.
- R4: Non-legacy modes then write 0x08 to address 0x12. Legacy mode does not.
- R5: Address 0x00 is always written with 0 next. In non-legacy modes it is then written with (fs<<5)|0x08, where fs is taken from `freq` (0: 200 MHz → 0, 1: 100 MHz → 2, 2: 50 MHz → 1, 3: other → 0).
- R6: After the DLL enable write, address 0x00 is read repeatedly until bit 4 is set, and only then is `done` given. Legacy mode issues no poll read.
- R7: After reset the first request always runs. A later request whose `freq` equals the last accepted one, including one whose sequence failed, makes no PHY access and pulses `done` in the cycle after `start`.
- R8: An access not acknowledged within ACC_TMO cycles is abandoned. The sequence ends with `done` and `error` high together, and no further access follows.
- R9: If bit 4 of address 0x00 is still clear after POLL_TMO cycles of polling, the sequence ends with `done` and `error`.
- R10: A `start` while `busy` is held and runs, with its own inputs, right after the running sequence completes.
- R11: Out of reset, `busy`, `done`, `error` and `phy_req` are low. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and `done` lasts one cycle.
- R12: Mode codes 6 and 7 make no PHY access and give `done` without `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| mode | input | 3 | Timing mode code |
| freq | input | 2 | Card clock frequency code |
| drv | input | 2 | Drive strength for pad control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| phy_req | output | 1 | PHY access request, held until ack |
| phy_we | output | 1 | 1 write, 0 read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | PHY write data |
| phy_ack | input | 1 | PHY access acknowledge, one cycle |
| phy_rdata | input | 8 | PHY read data, valid with ack |

## Verification
A wrong state or a bad transition shows at the PHY port on the very next access. A value, address or read/write flag is wrong, or an access is missing or extra, and the bench reference catches this the cycle it is acknowledged. A corrupted last-frequency record or pending flag shows at `done`: completion is either skipped or not, or a held request never runs. Both show within one sequence. A stuck poll or access counter shows as `error` with `done`, or as a completion that never comes.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_DLL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PAD  = 8'h01;
    localparam logic [ADDR_W-1:0] A_ITAP = 8'h0C;
    localparam logic [ADDR_W-1:0] A_OTAP = 8'h0D;
    localparam logic [ADDR_W-1:0] A_MODE = 8'h11;
    localparam logic [ADDR_W-1:0] A_TRIM = 8'h12;

    localparam logic [DATA_W-1:0] TRIM_VAL = 8'h08;
    localparam logic [DATA_W-1:0] DLL_ON   = 8'h08;
    localparam int                RDY_BIT  = 4;
    localparam int                DRV_SH   = 2;

    typedef enum logic [2:0] {
        TM_LEGACY = 3'd0,
        TM_HS     = 3'd1,
        TM_HS200  = 3'd2,
        TM_DDR    = 3'd3,
        TM_HS400  = 3'd4,
        TM_ESTRB  = 3'd5,
        TM_RSV6   = 3'd6,
        TM_RSV7   = 3'd7
    } tmode_e;

    typedef enum logic [1:0] {
        FQ_200   = 2'd0,
        FQ_100   = 2'd1,
        FQ_50    = 2'd2,
        FQ_OTHER = 2'd3
    } fsel_e;

    typedef struct packed {
        logic              valid;
        logic              legacy;
        logic              pad_rmw;
        logic [DATA_W-1:0] mode_val;
        logic [DATA_W-1:0] otap;
        logic [DATA_W-1:0] itap;
        logic [DATA_W-1:0] dll_en;
    } plan_t;

endpackage

// File: rtl/phycfg_decode.sv
module phycfg_decode
    import phycfg_pkg::*;
(
    input  tmode_e mode_i,
    input  fsel_e  freq_i,
    output plan_t  plan_o
);

    logic [2:0] fs;
    logic [3:0] ot;
    logic [3:0] it;
    logic       it_zero;

    always_comb begin
        unique case (freq_i)
            FQ_100:  fs = 3'd2;
            FQ_50:   fs = 3'd1;
            default: fs = 3'd0;
        endcase
    end

    always_comb begin
        plan_o          = '0;
        plan_o.valid    = 1'b1;
        ot              = 4'd0;
        it              = 4'd0;
        it_zero         = 1'b0;
        unique case (mode_i)
            TM_LEGACY: begin
                plan_o.legacy   = 1'b1;
                plan_o.mode_val = 8'h04;
            end
            TM_HS: begin
                plan_o.mode_val = 8'h00;
                ot              = 4'd3;
                it              = 4'd2;
            end
            TM_HS200: begin
                plan_o.mode_val = 8'h00;
                plan_o.pad_rmw  = 1'b1;
                ot              = 4'd2;
                it_zero         = 1'b1;
            end
            TM_DDR: begin
                plan_o.mode_val = 8'h08;
                ot              = 4'd1;
                it              = 4'd0;
            end
            TM_HS400: begin
                plan_o.mode_val = 8'h02;
                plan_o.pad_rmw  = 1'b1;
                ot              = 4'd1;
                it              = 4'd10;
            end
            TM_ESTRB: begin
                plan_o.mode_val = 8'h01;
                ot              = 4'd1;
                it              = 4'd0;
            end
            default: begin
                plan_o.valid    = 1'b0;
            end
        endcase
        if (plan_o.valid && !plan_o.legacy) begin
            plan_o.otap   = DATA_W'({ot, 1'b1});
            plan_o.itap   = it_zero ? '0 : DATA_W'({it, 1'b1});
            plan_o.dll_en = DATA_W'({fs, 5'b0}) | DLL_ON;
        end
    end

endmodule

// File: rtl/phycfg_port.sv
module phycfg_port
    import phycfg_pkg::*;
#(
    parameter int ACC_TMO = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              acc_done,
    output logic              acc_fail,
    output logic [DATA_W-1:0] acc_rdata
);

    localparam int CW = $clog2(ACC_TMO + 1);
    localparam logic [CW-1:0] LIM = CW'(ACC_TMO - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_req   <= 1'b0;
            phy_we    <= 1'b0;
            phy_addr  <= '0;
            phy_wdata <= '0;
            cnt_q     <= '0;
        end else if (go) begin
            phy_req   <= 1'b1;
            phy_we    <= go_we;
            phy_addr  <= go_addr;
            phy_wdata <= go_wdata;
            cnt_q     <= '0;
        end else if (phy_req) begin
            if (phy_ack || cnt_q == LIM) begin
                phy_req <= 1'b0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign acc_done  = phy_req && phy_ack;
    assign acc_fail  = phy_req && !phy_ack && (cnt_q == LIM);
    assign acc_rdata = phy_rdata;

endmodule

// File: rtl/phycfg_seq.sv
module phycfg_seq
    import phycfg_pkg::*;
#(
    parameter int POLL_TMO = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  tmode_e            mode_i,
    input  fsel_e             freq_i,
    input  logic [1:0]        drv_i,
    input  plan_t             plan,
    output tmode_e            cur_mode,
    output fsel_e             cur_freq,
    output logic              go,
    output logic              go_we,
    output logic [ADDR_W-1:0] go_addr,
    output logic [DATA_W-1:0] go_wdata,
    input  logic              acc_done,
    input  logic              acc_fail,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              busy,
    output logic              done,
    output logic              error
);

    localparam int PW = $clog2(POLL_TMO + 1);
    localparam logic [PW-1:0] PLIM = PW'(POLL_TMO);

    typedef enum logic [3:0] {
        S_IDLE, S_SET_MODE, S_PAD_READ, S_PAD_WRITE, S_OUT_TAP, S_IN_TAP,
        S_TRIM, S_DLL_CLEAR, S_DLL_ENABLE, S_DLL_POLL, S_FINISH
    } state_e;

    state_e            st_q, st_d;
    logic              launched_q;
    logic              fail_q;
    logic              pend_q;
    tmode_e            pmode_q;
    fsel_e             pfreq_q;
    logic [1:0]        pdrv_q;
    logic [1:0]        cdrv_q;
    fsel_e             last_freq_q;
    logic              last_vld_q;
    logic [DATA_W-1:0] pad_q;
    logic [PW-1:0]     poll_cnt_q;

    logic              trig;
    logic              skip;
    tmode_e            sel_mode;
    fsel_e             sel_freq;
    logic [1:0]        sel_drv;
    logic              acc_state;
    logic              poll_expired;
    logic              dll_ready;

    assign trig         = (st_q == S_IDLE) && (start || pend_q);
    assign sel_mode     = start ? mode_i : pmode_q;
    assign sel_freq     = start ? freq_i : pfreq_q;
    assign sel_drv      = start ? drv_i  : pdrv_q;
    assign skip         = last_vld_q && (sel_freq == last_freq_q);
    assign poll_expired = (poll_cnt_q >= PLIM);
    assign dll_ready    = acc_rdata[RDY_BIT];

    // access issued by each state
    always_comb begin
        acc_state = 1'b1;
        go_we     = 1'b1;
        go_addr   = '0;
        go_wdata  = '0;
        unique case (st_q)
            S_SET_MODE: begin
                acc_state = plan.valid;
                go_addr   = A_MODE;
                go_wdata  = plan.mode_val;
            end
            S_PAD_READ: begin
                go_we   = 1'b0;
                go_addr = A_PAD;
            end
            S_PAD_WRITE: begin
                go_addr  = A_PAD;
                go_wdata = pad_q | DATA_W'({cdrv_q, {DRV_SH{1'b0}}});
            end
            S_OUT_TAP: begin
                go_addr  = A_OTAP;
                go_wdata = plan.otap;
            end
            S_IN_TAP: begin
                go_addr  = A_ITAP;
                go_wdata = plan.itap;
            end
            S_TRIM: begin
                go_addr  = A_TRIM;
                go_wdata = TRIM_VAL;
            end
            S_DLL_CLEAR: begin
                go_addr  = A_DLL;
                go_wdata = '0;
            end
            S_DLL_ENABLE: begin
                go_addr  = A_DLL;
                go_wdata = plan.dll_en;
            end
            S_DLL_POLL: begin
                go_we   = 1'b0;
                go_addr = A_DLL;
            end
            default: begin
                acc_state = 1'b0;
            end
        endcase
        go = acc_state && !launched_q;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (trig) st_d = skip ? S_FINISH : S_SET_MODE;
            end
            S_SET_MODE: begin
                if (!plan.valid)   st_d = S_FINISH;
                else if (acc_fail) st_d = S_FINISH;
                else if (acc_done) st_d = plan.pad_rmw ? S_PAD_READ : S_OUT_TAP;
            end
            S_PAD_READ: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = S_PAD_WRITE;
            end
            S_PAD_WRITE: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = S_OUT_TAP;
            end
            S_OUT_TAP: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = S_IN_TAP;
            end
            S_IN_TAP: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = plan.legacy ? S_DLL_CLEAR : S_TRIM;
            end
            S_TRIM: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = S_DLL_CLEAR;
            end
            S_DLL_CLEAR: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = plan.legacy ? S_FINISH : S_DLL_ENABLE;
            end
            S_DLL_ENABLE: begin
                if (acc_fail)      st_d = S_FINISH;
                else if (acc_done) st_d = S_DLL_POLL;
            end
            S_DLL_POLL: begin
                if (acc_fail) st_d = S_FINISH;
                else if (acc_done && (dll_ready || poll_expired)) st_d = S_FINISH;
            end
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // sequence data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launched_q  <= 1'b0;
            fail_q      <= 1'b0;
            pend_q      <= 1'b0;
            pmode_q     <= TM_LEGACY;
            pfreq_q     <= FQ_200;
            pdrv_q      <= '0;
            cur_mode    <= TM_LEGACY;
            cur_freq    <= FQ_200;
            cdrv_q      <= '0;
            last_freq_q <= FQ_200;
            last_vld_q  <= 1'b0;
            pad_q       <= '0;
            poll_cnt_q  <= '0;
        end else begin
            if (go) launched_q <= 1'b1;
            else if (acc_done || acc_fail) launched_q <= 1'b0;

            if (start && st_q != S_IDLE) begin
                pend_q  <= 1'b1;
                pmode_q <= mode_i;
                pfreq_q <= freq_i;
                pdrv_q  <= drv_i;
            end else if (trig) begin
                pend_q  <= 1'b0;
            end

            if (trig) begin
                fail_q <= 1'b0;
                if (!skip) begin
                    cur_mode    <= sel_mode;
                    cur_freq    <= sel_freq;
                    cdrv_q      <= sel_drv;
                    last_freq_q <= sel_freq;
                    last_vld_q  <= 1'b1;
                end
            end

            if (acc_state && acc_fail) fail_q <= 1'b1;
            if (st_q == S_DLL_POLL && acc_done && !dll_ready && poll_expired)
                fail_q <= 1'b1;

            if (st_q == S_PAD_READ && acc_done) pad_q <= acc_rdata;

            if (st_q == S_DLL_ENABLE)    poll_cnt_q <= '0;
            else if (st_q == S_DLL_POLL && !poll_expired)
                poll_cnt_q <= poll_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy  = (st_q != S_IDLE);
        done  = (st_q == S_FINISH);
        error = (st_q == S_FINISH) && fail_q;
    end

endmodule

// File: rtl/phy_timing_cfg.sv
module phy_timing_cfg
    import phycfg_pkg::*;
#(
    parameter int ACC_TMO  = 256,
    parameter int POLL_TMO = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        freq,
    input  logic [1:0]        drv,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata
);

    tmode_e            cur_mode;
    fsel_e             cur_freq;
    plan_t             plan;
    logic              go;
    logic              go_we;
    logic [ADDR_W-1:0] go_addr;
    logic [DATA_W-1:0] go_wdata;
    logic              acc_done;
    logic              acc_fail;
    logic [DATA_W-1:0] acc_rdata;

    phycfg_decode u_dec (
        .mode_i (cur_mode),
        .freq_i (cur_freq),
        .plan_o (plan)
    );

    phycfg_seq #(.POLL_TMO(POLL_TMO)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_i    (tmode_e'(mode)),
        .freq_i    (fsel_e'(freq)),
        .drv_i     (drv),
        .plan      (plan),
        .cur_mode  (cur_mode),
        .cur_freq  (cur_freq),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .acc_done  (acc_done),
        .acc_fail  (acc_fail),
        .acc_rdata (acc_rdata),
        .busy      (busy),
        .done      (done),
        .error     (error)
    );

    phycfg_port #(.ACC_TMO(ACC_TMO)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .acc_done  (acc_done),
        .acc_fail  (acc_fail),
        .acc_rdata (acc_rdata)
    );

endmodule

// File: rtl/phy_timing_cfg_chk.sv
module phy_timing_cfg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       phy_req,
    input logic       phy_we,
    input logic [7:0] phy_addr,
    input logic [7:0] phy_wdata,
    input logic       phy_ack
);

    AST_ERROR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R8

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R11

    AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11

    AST_REQ_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req |-> busy); // R11

    AST_REQ_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R1

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !phy_req); // R6

endmodule

bind phy_timing_cfg phy_timing_cfg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack)
);

// File: tb/sim_phy_timing_cfg.sv
module sim_phy_timing_cfg;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_TMO    = 12;
    localparam int POLL_TMO   = 80;
    localparam int LAT        = 2;
    localparam int RDY_N      = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic [1:0] freq = '0;
    logic [1:0] drv = '0;
    logic       busy, done, error;
    logic       phy_req, phy_we;
    logic [7:0] phy_addr, phy_wdata;
    logic       phy_ack = 1'b0;
    logic [7:0] phy_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_timing_cfg #(.ACC_TMO(ACC_TMO), .POLL_TMO(POLL_TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .freq(freq),
        .drv(drv), .busy(busy), .done(done), .error(error),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    int   done_cnt = 0;
    logic last_err = 1'b0;

    logic [7:0] mem [256];
    int   wait_cnt = 0;
    int   dll_reads = 0;
    bit   no_ack = 0;
    bit   dll_dead = 0;
    bit   tolerate_poll = 0;
    int   exp_q[$];
    logic [7:0] model_pad = 8'h41;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // PHY register slave and transaction comparison
    always @(negedge clk) begin
        cycles++;
        if (done) begin
            done_cnt++;
            last_err = error;
        end
        if (!rst_n) begin
            phy_ack  = 1'b0;
            wait_cnt = 0;
        end else if (phy_ack) begin
            phy_ack = 1'b0;
        end else if (phy_req && !no_ack) begin
            wait_cnt++;
            if (wait_cnt >= LAT) begin
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(tolerate_poll && !phy_we && phy_addr == 8'h00,
                        "R6/R9 unexpected access", {phy_we, phy_addr}, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e[16])
                        chk({phy_we, phy_addr, phy_wdata} == e[16:0],
                            "R1-order write", {phy_we, phy_addr, phy_wdata}, e);
                    else
                        chk({phy_we, phy_addr} == e[16:8],
                            "R2/R6 read", {phy_we, phy_addr}, e[16:8]);
                end
                if (phy_we) begin
                    mem[phy_addr] = phy_wdata;
                    if (phy_addr == 8'h00) dll_reads = 0;
                end else if (phy_addr == 8'h00) begin
                    phy_rdata = (!dll_dead && dll_reads >= RDY_N) ? 8'h10 : 8'h00;
                    dll_reads++;
                end else begin
                    phy_rdata = mem[phy_addr];
                end
                phy_ack = 1'b1;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic push_w(input int a, input int d);
        exp_q.push_back((1 << 16) | (a << 8) | d);
    endtask

    task automatic push_r(input int a);
        exp_q.push_back(a << 8);
    endtask

    // reference sequence built from the requirements
    task automatic build(input int m, input int f, input int d, input bit dead);
        int mv, ot, it, fs;
        if (m > 5) return; // R12
        case (m)
            0: mv = 8'h04; 3: mv = 8'h08; 4: mv = 8'h02; 5: mv = 8'h01;
            default: mv = 0;
        endcase
        case (m)
            1: begin ot = 3; it = 2; end
            2: begin ot = 2; it = 0; end
            4: begin ot = 1; it = 10; end
            default: begin ot = 1; it = 0; end
        endcase
        fs = (f == 1) ? 2 : (f == 2) ? 1 : 0;
        push_w(8'h11, mv);                        // R1
        if (m == 2 || m == 4) begin               // R2
            push_r(8'h01);
            model_pad = model_pad | 8'(d << 2);
            push_w(8'h01, model_pad);
        end
        if (m == 0) begin                         // R3
            push_w(8'h0D, 0);
            push_w(8'h0C, 0);
        end else begin
            push_w(8'h0D, ot * 2 + 1);
            push_w(8'h0C, (m == 2) ? 0 : it * 2 + 1);
            push_w(8'h12, 8'h08);                 // R4
        end
        push_w(8'h00, 0);                         // R5
        if (m != 0) begin
            push_w(8'h00, fs * 32 + 8);
            if (dead) push_r(8'h00);
            else for (int k = 0; k <= RDY_N; k++) push_r(8'h00); // R6
        end
    endtask

    task automatic kick(input int m, input int f, input int d);
        @(negedge clk);
        mode = 3'(m); freq = 2'(f); drv = 2'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic await(input int target, input bit exp_err, input string tag);
        int n;
        n = 0;
        while (done_cnt < target && n < 6000) begin
            @(negedge clk); #1;
            n++;
        end
        chk(done_cnt >= target, {tag, " done seen"}, done_cnt, target);
        chk(last_err == exp_err, {tag, " error flag"}, last_err, exp_err);
        chk(exp_q.size() == 0, {tag, " all accesses made"}, exp_q.size(), 0);
    endtask

    task automatic run(input int m, input int f, input int d, input bit exp_err, input string tag);
        int t;
        t = done_cnt + 1;
        build(m, f, d, 0);
        kick(m, f, d);
        await(t, exp_err, tag);
    endtask

    initial begin
        foreach (mem[i]) mem[i] = 8'h00;
        mem[1] = 8'h41;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !error && !phy_req, "R11 reset outputs", {busy, done, error, phy_req}, 0);

        run(4, 0, 2, 0, "R1 R2 R3 HS400 200MHz");
        run(2, 1, 1, 0, "R2 R3 HS200 100MHz");
        run(0, 2, 3, 0, "R3 R4 legacy 50MHz");
        run(3, 3, 0, 0, "R5 DDR50 other");
        run(1, 0, 0, 0, "R3 R5 high-speed 200MHz");
        run(5, 1, 0, 0, "R6 enhanced strobe 100MHz");

        // R7 skip on same frequency
        begin
            int t;
            t = done_cnt;
            kick(0, 1, 0);
            chk(done === 1'b1, "R7 skip done next cycle", done, 1);
            chk(busy === 1'b1, "R11 busy during skip", busy, 1);
            await(t + 1, 0, "R7 skip");
        end

        run(6, 2, 0, 0, "R12 unused mode code");

        // R8 access timeout
        no_ack = 1;
        begin
            int t;
            t = done_cnt + 1;
            kick(1, 0, 0);
            await(t, 1, "R8 access timeout");
        end
        @(negedge clk);
        chk(!phy_req && !busy, "R8 no access after failure", {phy_req, busy}, 0);
        no_ack = 0;
        begin
            int t;
            t = done_cnt + 1;
            kick(3, 0, 0);
            await(t, 0, "R7 skip after failed run");
        end

        // R9 DLL ready never comes
        dll_dead = 1;
        tolerate_poll = 1;
        begin
            int t;
            t = done_cnt + 1;
            build(4, 1, 0, 1);
            kick(4, 1, 0);
            await(t, 1, "R9 poll timeout");
        end
        dll_dead = 0;
        tolerate_poll = 0;

        // R10 start while busy
        begin
            int t;
            t = done_cnt + 2;
            build(3, 2, 0, 0);
            build(1, 0, 0, 0);
            kick(3, 2, 0);
            repeat (4) @(negedge clk);
            chk(busy === 1'b1, "R10 first still busy", busy, 1);
            kick(1, 0, 0);
            await(t, 0, "R10 held request");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule